// File: doc/BRIEF.md
# Microprogrammed Control Sequencer for a Multicycle 32-bit Integer Core

This block steps a small multicycle integer datapath through each instruction. A 7-bit micro-state register indexes a combinational control store. Every cycle the store yields one wide control word: load strobes, bus drivers, multiplexer selects, register-file read enables and memory strobes. The datapath, register file, ALU and memory sit outside the block and consume that word directly.

The next micro-state normally comes from the word's own 7-bit jump field. In the decode state it comes from the instruction's 7-bit opcode instead, so every supported instruction class starts in the micro-state whose number is its opcode. A conditional-branch flow forks on the branch flag by setting one bit of the jump target. Micro-states that touch memory stall until the memory signals ready.

Top module: `useq_ctrl`

## Requirements
- R1: While the synchronised reset is active, the micro-state is 0. After `rst_n` rises, the state stays 0 through two rising clock edges. The first state change comes on the third edge.
- R2: The fetch runs 0 → 1 → 5 → 7. State 0 pulses `pc_load` and `mar_load`. State 1 pulses `mdr_load` and `mem_en`. State 5 pulses `ir_load`. The load strobes sit at `ctrl_word[25:20]` as {pc, mar, mdr, ir, regfile, branch-flag}. `mem_en` is bit 4 and `mem_wr` is bit 3.
- R3: In states 1, 2 and 33, the state and control word hold unchanged while `mem_ready` is low. The sequence advances on the first edge with `mem_ready` high.
- R4: From state 7, the next state equals `instr_op` when it is one of 19, 51, 3, 35, 99, 55, 111 or 103.
- R5: Any other opcode in state 7 leads to state 127. State 127 drives every load strobe and `mem_wr` low, then returns to state 0.
- R6: A load runs 3 → 2 → 6 → 0. State 3 loads MAR, state 2 loads MDR with `mem_en`, and state 6 writes the register file.
- R7: A store runs 35 → 32 → 33 → 0. State 35 loads MAR and state 32 loads MDR. `mem_wr` is high in state 33 and in no other state.
- R8: A branch runs 99 → 100. State 100 pulses the branch-flag load and moves to 104 when `branch_flag` is high, or to 96 when it is low. State 104 loads PC and returns to 0. State 96 sets the flag-clear bit `ctrl_word[0]`, loads PC and MAR, and goes to 1.
- R9: The jump-and-link flow runs 111 → 112 → 0, and the register-indirect jump flow runs 103 → 102 → 0. The first state of each writes the register file and the second loads PC.
- R10: Immediate-ALU (19), register-ALU (51) and upper-immediate (55) each write the register file for one cycle and return to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_op | input | 7 | Opcode field of the instruction register |
| branch_flag | input | 1 | Branch condition from the datapath comparator |
| mem_ready | input | 1 | Memory has completed the current access |
| ctrl_word | output | 34 | Control word. MSB first: decode, jump[6:0], loads PC/MAR/MDR/IR/RF/flag, drives PC/MAR/MDR/ALU/RS2, pc_sel[1:0], addr1_sel, addr2_sel[1:0], mar_sel, mdr_sel, rs2_sel, rs1_en, rs2_en, mem_en, mem_wr, mem_size[1:0], flag_clear |
| ustate | output | 7 | Current micro-state |

## Verification
The assertions rely on two assumptions about the inputs. First, `mem_ready` is meaningful only while a memory state is active. Second, `instr_op` is stable during the decode cycle, because the datapath loaded it into the instruction register one cycle earlier. The stimulus changes the opcode only while the sequencer is back in state 0, and it holds it through the whole instruction. It lowers `mem_ready` for two cycles in the memory states on alternate instructions, and it drives `branch_flag` both ways in the fork state. The opcodes used include two that are not in the supported set.

// File: rtl/uc_pkg.sv
package uc_pkg;
  localparam int ST_W = 7;

  typedef struct packed {
    logic            decode_en;
    logic [ST_W-1:0] jump;
    logic            pc_load;
    logic            mar_load;
    logic            mdr_load;
    logic            ir_load;
    logic            rf_write;
    logic            cond_load;
    logic            drive_pc;
    logic            drive_mar;
    logic            drive_mdr;
    logic            drive_alu;
    logic            drive_rs2;
    logic [1:0]      pc_sel;
    logic            addr1_sel;
    logic [1:0]      addr2_sel;
    logic            mar_sel;
    logic            mdr_sel;
    logic            rs2_sel;
    logic            rs1_en;
    logic            rs2_en;
    logic            mem_en;
    logic            mem_wr;
    logic [1:0]      mem_size;
    logic            cond_clear;
  } uword_t;

  localparam int UW_W = $bits(uword_t);

  localparam logic [ST_W-1:0] ST_FETCH   = 7'd0;
  localparam logic [ST_W-1:0] ST_FETCH2  = 7'd37;
  localparam logic [ST_W-1:0] ST_IRD     = 7'd1;
  localparam logic [ST_W-1:0] ST_IRLD    = 7'd5;
  localparam logic [ST_W-1:0] ST_DECODE  = 7'd7;
  localparam logic [ST_W-1:0] ST_ALUI    = 7'd19;
  localparam logic [ST_W-1:0] ST_ALUR    = 7'd51;
  localparam logic [ST_W-1:0] ST_CMP     = 7'd99;
  localparam logic [ST_W-1:0] ST_FORK    = 7'd100;
  localparam logic [ST_W-1:0] ST_NTAKEN  = 7'd96;
  localparam logic [ST_W-1:0] ST_TAKEN   = 7'd104;
  localparam logic [ST_W-1:0] ST_LDADDR  = 7'd3;
  localparam logic [ST_W-1:0] ST_LDMEM   = 7'd2;
  localparam logic [ST_W-1:0] ST_LDWB    = 7'd6;
  localparam logic [ST_W-1:0] ST_STADDR  = 7'd35;
  localparam logic [ST_W-1:0] ST_STDATA  = 7'd32;
  localparam logic [ST_W-1:0] ST_STMEM   = 7'd33;
  localparam logic [ST_W-1:0] ST_UPPER   = 7'd55;
  localparam logic [ST_W-1:0] ST_JLINK   = 7'd111;
  localparam logic [ST_W-1:0] ST_JTGT    = 7'd112;
  localparam logic [ST_W-1:0] ST_RLINK   = 7'd103;
  localparam logic [ST_W-1:0] ST_RTGT    = 7'd102;
  localparam logic [ST_W-1:0] ST_ILLEGAL = {ST_W{1'b1}};

  function automatic logic op_known(logic [ST_W-1:0] op);
    return op inside {ST_ALUI, ST_ALUR, ST_CMP, ST_LDADDR,
                      ST_STADDR, ST_UPPER, ST_JLINK, ST_RLINK};
  endfunction
endpackage

// File: rtl/uc_rst_sync.sv
module uc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/uc_store.sv
module uc_store
  import uc_pkg::*;
(
  input  logic [ST_W-1:0] state,
  output uword_t          word
);
  localparam logic [1:0] SZ_WORD  = 2'b10;
  localparam logic [1:0] PC_INC   = 2'd0;
  localparam logic [1:0] PC_ADDER = 2'd1;
  localparam logic [1:0] A2_IMM12 = 2'd1;
  localparam logic [1:0] A2_SIMM  = 2'd2;
  localparam logic [1:0] A2_IMM20 = 2'd3;

  always_comb begin
    word = '0;
    unique case (state)
      ST_FETCH, ST_FETCH2, ST_NTAKEN: begin
        word.jump       = ST_IRD;
        word.pc_load    = 1'b1;
        word.mar_load   = 1'b1;
        word.drive_pc   = 1'b1;
        word.pc_sel     = PC_INC;
        word.cond_clear = (state == ST_NTAKEN);
      end
      ST_IRD, ST_LDMEM: begin
        word.jump     = (state == ST_IRD) ? ST_IRLD : ST_LDWB;
        word.mdr_load = 1'b1;
        word.mdr_sel  = 1'b1;
        word.mem_en   = 1'b1;
        word.mem_size = SZ_WORD;
      end
      ST_IRLD: begin
        word.jump      = ST_DECODE;
        word.ir_load   = 1'b1;
        word.drive_mdr = 1'b1;
      end
      ST_DECODE: word.decode_en = 1'b1;
      ST_ALUI, ST_ALUR: begin
        word.rf_write  = 1'b1;
        word.drive_alu = 1'b1;
        word.rs1_en    = 1'b1;
        word.rs2_en    = (state == ST_ALUR);
        word.rs2_sel   = (state == ST_ALUI);
      end
      ST_CMP: begin
        word.jump      = ST_FORK;
        word.drive_alu = 1'b1;
        word.rs1_en    = 1'b1;
        word.rs2_en    = 1'b1;
      end
      ST_FORK: begin
        word.jump      = ST_NTAKEN;
        word.cond_load = 1'b1;
      end
      ST_TAKEN, ST_JTGT, ST_RTGT: begin
        word.pc_load   = 1'b1;
        word.pc_sel    = PC_ADDER;
        word.addr1_sel = (state == ST_RTGT);
        word.rs1_en    = (state == ST_RTGT);
        word.addr2_sel = (state == ST_JTGT) ? A2_IMM20 : A2_IMM12;
      end
      ST_LDADDR, ST_STADDR: begin
        word.jump      = (state == ST_LDADDR) ? ST_LDMEM : ST_STDATA;
        word.mar_load  = 1'b1;
        word.drive_mar = 1'b1;
        word.addr1_sel = 1'b1;
        word.rs1_en    = 1'b1;
        word.addr2_sel = (state == ST_LDADDR) ? A2_IMM12 : A2_SIMM;
      end
      ST_LDWB: begin
        word.rf_write  = 1'b1;
        word.drive_mdr = 1'b1;
      end
      ST_STDATA: begin
        word.jump      = ST_STMEM;
        word.mdr_load  = 1'b1;
        word.drive_rs2 = 1'b1;
        word.rs2_en    = 1'b1;
      end
      ST_STMEM: begin
        word.mem_en   = 1'b1;
        word.mem_wr   = 1'b1;
        word.mem_size = SZ_WORD;
      end
      ST_UPPER: begin
        word.rf_write  = 1'b1;
        word.mar_sel   = 1'b1;
        word.drive_mar = 1'b1;
      end
      ST_JLINK, ST_RLINK: begin
        word.jump     = (state == ST_JLINK) ? ST_JTGT : ST_RTGT;
        word.rf_write = 1'b1;
        word.drive_pc = 1'b1;
      end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/uc_next.sv
module uc_next
  import uc_pkg::*;
#(
  parameter int FORK_BIT = 3
) (
  input  logic            decode_en,
  input  logic            cond_load,
  input  logic [ST_W-1:0] jump,
  input  logic [ST_W-1:0] opcode,
  input  logic            branch_flag,
  output logic [ST_W-1:0] nxt
);
  localparam logic [ST_W-1:0] FORK_MASK = ST_W'(1) << FORK_BIT;

  always_comb begin
    if (decode_en)
      nxt = op_known(opcode) ? opcode : ST_ILLEGAL;
    else if (cond_load && branch_flag)
      nxt = jump | FORK_MASK;
    else
      nxt = jump;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import uc_pkg::*;
#(
  parameter int RST_STAGES = 2,
  parameter int FORK_BIT   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] instr_op,
  input  logic            branch_flag,
  input  logic            mem_ready,
  output logic [UW_W-1:0] ctrl_word,
  output logic [ST_W-1:0] ustate
);
  logic            rst_q;
  uword_t          word;
  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] state_d;
  logic            state_en;

  uc_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  uc_store i_store (.state(state_q), .word(word));

  uc_next #(.FORK_BIT(FORK_BIT)) i_next (
    .decode_en(word.decode_en), .cond_load(word.cond_load), .jump(word.jump),
    .opcode(instr_op), .branch_flag(branch_flag), .nxt(state_d)
  );

  assign state_en = !(word.mem_en && !mem_ready);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)        state_q <= ST_FETCH;
    else if (state_en) state_q <= state_d;
  end

  assign ctrl_word = word;
  assign ustate    = state_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (((ustate == ST_IRD) || (ustate == ST_LDMEM) || (ustate == ST_STMEM)) && !mem_ready)
      |=> $stable(ustate)); // R3
  AST_DECODE_TARGET: assert property (@(posedge clk) disable iff (!rst_q)
    (ustate == ST_DECODE) |=> ((ustate == $past(instr_op)) || (ustate == ST_ILLEGAL))); // R4
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    (ustate == ST_ILLEGAL) |-> (ctrl_word[25:20] == '0 && !ctrl_word[3])); // R5
  AST_ILLEGAL_RETURN: assert property (@(posedge clk) disable iff (!rst_q)
    (ustate == ST_ILLEGAL) |=> (ustate == ST_FETCH)); // R5
  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_q)
    ctrl_word[3] |-> (ustate == ST_STMEM)); // R7
  AST_FORK_TARGET: assert property (@(posedge clk) disable iff (!rst_q)
    (ustate == ST_FORK) |=> ((ustate == ST_TAKEN) == $past(branch_flag)) &&
                            ((ustate == ST_TAKEN) || (ustate == ST_NTAKEN))); // R8
endmodule

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
module test_useq_ctrl;
  logic        clk;
  logic        rst_n;
  logic [6:0]  instr_op;
  logic        branch_flag;
  logic        mem_ready;
  logic [33:0] ctrl_word;
  logic [6:0]  ustate;

  int checks = 0;
  int errors = 0;
  int exp_st = 0;
  bit finished = 0;

  useq_ctrl i_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_op(instr_op), .branch_flag(branch_flag),
    .mem_ready(mem_ready), .ctrl_word(ctrl_word), .ustate(ustate)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit known(int op);
    return op == 19 || op == 51 || op == 3 || op == 35 ||
           op == 99 || op == 55 || op == 111 || op == 103;
  endfunction

  function automatic int model_next(int s, int op, bit f, bit r);
    case (s)
      0, 37, 96: return 1;
      1:   return r ? 5 : 1;
      5:   return 7;
      7:   return known(op) ? op : 127;
      3:   return 2;
      2:   return r ? 6 : 2;
      35:  return 32;
      32:  return 33;
      33:  return r ? 0 : 33;
      99:  return 100;
      100: return f ? 104 : 96;
      111: return 112;
      103: return 102;
      default: return 0;
    endcase
  endfunction

  // {pc, mar, mdr, ir, regfile, flag}
  function automatic logic [5:0] model_loads(int s);
    case (s)
      0, 37, 96: return 6'b110000;
      1, 2, 32:  return 6'b001000;
      5:         return 6'b000100;
      3, 35:     return 6'b010000;
      6, 19, 51, 55, 111, 103: return 6'b000010;
      100:       return 6'b000001;
      104, 112, 102: return 6'b100000;
      default:   return 6'b000000;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0, 1, 5: return "R2";
      7:   return "R4";
      127: return "R5";
      3, 2, 6: return "R6";
      35, 32, 33: return "R7";
      99, 100, 104, 96: return "R8";
      111, 112, 103, 102: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (state %0d)", tag, act, exp, exp_st);
    end
  endtask

  task automatic check_state(string tag);
    check(tag, 64'(ustate), 64'(exp_st));
    check(tag, 64'(ctrl_word[25:20]), 64'(model_loads(exp_st)));
    check(tag, 64'(ctrl_word[4]), 64'(exp_st == 1 || exp_st == 2 || exp_st == 33));
    check(tag, 64'(ctrl_word[3]), 64'(exp_st == 33));
    check(tag, 64'(ctrl_word[0]), 64'(exp_st == 96));
  endtask

  // one clock: drive at negedge, compare after the following posedge
  task automatic cyc(int op, bit f, bit r);
    int nxt;
    bool_hold: begin end
    instr_op    = 7'(op);
    branch_flag = f;
    mem_ready   = r;
    nxt = model_next(exp_st, op, f, r);
    @(negedge clk);
    if (nxt == exp_st && (nxt == 1 || nxt == 2 || nxt == 33) && !r) begin
      check_state("R3");
    end else begin
      exp_st = nxt;
      check_state(tag_of(exp_st));
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int ops [11] = '{19, 51, 3, 35, 99, 99, 55, 111, 103, 15, 127};
    rst_n = 1'b1;
    instr_op = '0;
    branch_flag = 1'b0;
    mem_ready = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_st = 0;
    check_state("R1");
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check_state("R1");
    end
    for (int i = 0; i < 11; i++) begin
      bit flag = (i != 5);
      int hold = 0;
      int guard = 0;
      do begin
        bit rdy = 1'b1;
        if ((exp_st == 1 || exp_st == 2 || exp_st == 33) && (i % 2 == 1) && hold < 2) begin
          rdy = 1'b0;
          hold++;
        end else if (!(exp_st == 1 || exp_st == 2 || exp_st == 33)) begin
          hold = 0;
        end
        if (exp_st == 96) flag = 1'b1;
        cyc(ops[i], flag, rdy);
        guard++;
      end while (exp_st != 0 && guard < 60);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule